// File: doc/BRIEF.md
# Serial PLL Configuration Loader

This block programs an external clock synthesizer whose configuration is loaded one bit at a time. A 56-bit programming word, presented as seven bytes on a parallel port, is captured when a start request is accepted. The block then issues one register write per bit, each marked by a single-cycle strobe. The strobe carries the bit on a serial data line. A hold flag rides along with the very last bit only, so the synthesizer latches the complete word on that write without an extra cycle.

The gap between successive strobes is programmable, with a minimum of one idle cycle. The gap value and the word are both sampled when a transfer is accepted. Requests made while a transfer is running are ignored. A one-cycle done pulse follows the final write.

Top module: `pll_serial_loader`

## Requirements
- R1: While rst_n is low, and directly after it, busy_o, done_o, strobe_o, sdata_o and hold_o are all low.
- R2: A start_i sampled high at a clock edge while busy_o is low starts a transfer: in the following cycle busy_o is high and strobe_o carries the first bit. Without a start, strobe_o stays low.
- R3: A transfer issues exactly 56 strobes. Byte k of the word is cfg_i[8k+7:8k]. Bytes go out in order 0 to 6, and within each byte bit 7 goes first and bit 0 last.
- R4: sdata_o equals the current bit while strobe_o is high, and is low whenever strobe_o is low.
- R5: hold_o is high together with the 56th strobe (byte 6, bit 0) and low on the 55 earlier strobes and between strobes.
- R6: Between two successive strobes there are exactly G cycles with strobe_o low. G is gap_i sampled with the start, and a value of 0 is treated as 1.
- R7: done_o is high for exactly one cycle, the cycle right after the final strobe. busy_o stays high through that cycle and is low in the next one.
- R8: start_i, cfg_i and gap_i are ignored while busy_o is high; a transfer sends the word and the gap captured at its own start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Transfer request, taken only while idle |
| cfg_i | input | 56 | Programming word, byte k in bits 8k+7..8k |
| gap_i | input | 4 | Idle cycles between strobes (0 means 1) |
| busy_o | output | 1 | Transfer in progress, including the done cycle |
| done_o | output | 1 | One-cycle pulse after the final write |
| strobe_o | output | 1 | One-cycle marker for each register write |
| sdata_o | output | 1 | Serial bit of the current write |
| hold_o | output | 1 | Latch flag, set only on the last write |

## Verification
The assertions assume that a transfer begins only through a start sampled while busy_o is low. They count strobes from that accepted start, so they are not valid when the synthesizer side is driven some other way. They also assume that rst_n is released synchronously to the clock.

The bench drives every input at the falling edge, so each start is a clean single-cycle request. While a transfer is running, it deliberately toggles start_i, cfg_i and gap_i to show that these inputs are ignored. It keeps gap_i small so that each run of 56 writes stays short.

// File: rtl/pll_ldr_pkg.sv
package pll_ldr_pkg;

  // Sequencer states of the loader.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2,
    ST_DONE = 2'd3
  } ldr_state_e;

  // Helper: effective gap, where zero is raised to the one-cycle minimum.
  function automatic int unsigned eff_gap(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

endpackage

// File: rtl/pll_ldr_shifter.sv
module pll_ldr_shifter #(
  parameter int NUM_BYTES = 7,
  parameter int BYTE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] cfg_i,
  input  logic                        adv_i,
  output logic                        bit_o,
  output logic                        last_o
);

  localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(NUM_BYTES - 1);
  localparam logic [BIT_W-1:0] TOP_BIT   = BIT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] byte_q [NUM_BYTES];
  logic [IDX_W-1:0]  byte_idx_q, byte_idx_d;
  logic [BIT_W-1:0]  bit_idx_q, bit_idx_d;
  logic [BYTE_W-1:0] cur_byte;

  // Byte storage: one enabled register per byte.
  genvar gb;
  generate
    for (gb = 0; gb < NUM_BYTES; gb++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          byte_q[gb] <= '0;
        end else if (load_i) begin
          byte_q[gb] <= cfg_i[gb*BYTE_W +: BYTE_W];
        end
      end
    end
  endgenerate

  // Position counters: byte ascending, bit descending.
  always_comb begin
    byte_idx_d = byte_idx_q;
    bit_idx_d  = bit_idx_q;
    if (load_i) begin
      byte_idx_d = '0;
      bit_idx_d  = TOP_BIT;
    end else if (adv_i) begin
      if (bit_idx_q == '0) begin
        bit_idx_d  = TOP_BIT;
        byte_idx_d = byte_idx_q + 1'b1;
      end else begin
        bit_idx_d  = bit_idx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_idx_q <= '0;
      bit_idx_q  <= '0;
    end else if (load_i || adv_i) begin
      byte_idx_q <= byte_idx_d;
      bit_idx_q  <= bit_idx_d;
    end
  end

  // Byte select mux, written without out-of-range indexing.
  always_comb begin
    cur_byte = '0;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (byte_idx_q == IDX_W'(k)) cur_byte = byte_q[k];
    end
  end

  assign bit_o  = cur_byte[bit_idx_q];
  assign last_o = (byte_idx_q == LAST_BYTE) && (bit_idx_q == '0);

endmodule

// File: rtl/pll_ldr_ctrl.sv
module pll_ldr_ctrl
  import pll_ldr_pkg::*;
#(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             last_i,
  output logic             load_o,
  output logic             strobe_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

  ldr_state_e       state_q, state_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             accept;

  assign accept = (state_q == ST_IDLE) && start_i;

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SEND;
          gap_d   = (gap_i == '0) ? GAP_ONE : gap_i;
        end
      end
      ST_SEND: begin
        if (last_i) begin
          state_d = ST_DONE;
        end else begin
          state_d = ST_GAP;
          cnt_d   = gap_q - 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == '0) begin
          state_d = ST_SEND;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gap_q   <= GAP_ONE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) gap_q <= gap_d;
      if (state_q != ST_IDLE) cnt_q <= cnt_d;
    end
  end

  assign load_o   = accept;
  assign strobe_o = (state_q == ST_SEND);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);

endmodule

// File: rtl/pll_serial_loader.sv
module pll_serial_loader #(
  parameter int NUM_BYTES = 7,
  parameter int BYTE_W    = 8,
  parameter int GAP_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] cfg_i,
  input  logic [GAP_W-1:0]            gap_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        strobe_o,
  output logic                        sdata_o,
  output logic                        hold_o
);

  logic load;
  logic strobe;
  logic cur_bit;
  logic last_bit;

  pll_ldr_ctrl #(
    .GAP_W (GAP_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .gap_i    (gap_i),
    .last_i   (last_bit),
    .load_o   (load),
    .strobe_o (strobe),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  pll_ldr_shifter #(
    .NUM_BYTES (NUM_BYTES),
    .BYTE_W    (BYTE_W)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .cfg_i  (cfg_i),
    .adv_i  (strobe),
    .bit_o  (cur_bit),
    .last_o (last_bit)
  );

  // Data and hold only appear on a write cycle.
  assign strobe_o = strobe;
  assign sdata_o  = strobe & cur_bit;
  assign hold_o   = strobe & last_bit;

endmodule

// File: rtl/pll_ldr_chk.sv
module pll_ldr_chk #(
  parameter int NUM_BYTES = 7,
  parameter int BYTE_W    = 8
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic strobe_o,
  input logic sdata_o,
  input logic hold_o
);

  localparam int TOTAL = NUM_BYTES * BYTE_W;

  logic [15:0] seen_q;

  // Strobes counted since the last accepted start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (start_i && !busy_o) begin
      seen_q <= '0;
    end else if (strobe_o) begin
      seen_q <= seen_q + 16'd1;
    end
  end

  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_o |-> !sdata_o); // R4

  AST_HOLD_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> (strobe_o && seen_q == 16'(TOTAL - 1))); // R5

  AST_LAST_HAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && seen_q == 16'(TOTAL - 1)) |-> hold_o); // R5

  AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o); // R6

  AST_DONE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(hold_o) && seen_q == 16'(TOTAL))); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R7

  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> busy_o); // R2

endmodule

bind pll_serial_loader pll_ldr_chk #(
  .NUM_BYTES (NUM_BYTES),
  .BYTE_W    (BYTE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .strobe_o (strobe_o),
  .sdata_o  (sdata_o),
  .hold_o   (hold_o)
);

// File: tb/tb_pll_serial_loader.sv
module tb_pll_serial_loader;

  localparam int NB  = 7;
  localparam int BW  = 8;
  localparam int GW  = 4;
  localparam int TOT = NB * BW;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start_i;
  logic [TOT-1:0]  cfg_i;
  logic [GW-1:0]   gap_i;
  logic            busy_o, done_o, strobe_o, sdata_o, hold_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pll_serial_loader #(.NUM_BYTES(NB), .BYTE_W(BW), .GAP_W(GW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i), .gap_i(gap_i),
    .busy_o(busy_o), .done_o(done_o), .strobe_o(strobe_o),
    .sdata_o(sdata_o), .hold_o(hold_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] out_vec();
    return {busy_o, done_o, strobe_o, sdata_o, hold_o};
  endfunction

  // R1: outputs quiet in and right after reset.
  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; cfg_i = '0; gap_i = '0;
    repeat (3) @(negedge clk);
    check(out_vec() == 5'b0, "R1", "outputs in reset", out_vec(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_vec() == 5'b0, "R1", "outputs after reset", out_vec(), 0);
  endtask

  // R2: no start, no strobe.
  task automatic t_idle();
    int seen = 0;
    start_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (strobe_o || busy_o) seen++;
    end
    check(seen == 0, "R2", "activity while idle", seen, 0);
  endtask

  // R2..R8: one full transfer with stream checking.
  task automatic t_xfer(input logic [TOT-1:0] word, input int gap, input bit disturb);
    int eff = (gap == 0) ? 1 : gap;
    int nstrb = 0, bad_bit = 0, bad_hold = 0, bad_quiet = 0, bad_gap = 0, lowrun = 0;
    bit done_seen = 0, done_ok = 0, first_ok;
    @(negedge clk);
    cfg_i = word; gap_i = GW'(gap); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    first_ok = strobe_o && busy_o;
    for (int cyc = 0; cyc < TOT * (eff + 1) + 10 && !done_seen; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (done_o) begin
        done_seen = 1;
        done_ok = (nstrb == TOT) && (lowrun == 0) && busy_o;
      end else if (strobe_o) begin
        if (sdata_o != word[(nstrb / BW) * BW + (BW - 1) - (nstrb % BW)]) bad_bit++;
        if (hold_o != (nstrb == TOT - 1)) bad_hold++;
        if (nstrb > 0 && lowrun != eff) bad_gap++;
        nstrb++;
        lowrun = 0;
      end else begin
        if (sdata_o || hold_o) bad_quiet++;
        lowrun++;
      end
      if (disturb && busy_o) begin
        start_i = cyc[0];
        cfg_i   = ~cfg_i ^ TOT'(cyc);
        gap_i   = gap_i + 1'b1;
      end
    end
    start_i = 1'b0;
    check(first_ok, "R2", "first strobe after start", first_ok, 1);
    check(nstrb == TOT, "R3", "strobe count", nstrb, TOT);
    check(bad_bit == 0, "R3", "bit order mismatches", bad_bit, 0);
    check(bad_quiet == 0, "R4", "data or hold between strobes", bad_quiet, 0);
    check(bad_hold == 0, "R5", "hold placement errors", bad_hold, 0);
    check(bad_gap == 0, "R6", "gap length errors", bad_gap, 0);
    check(done_seen && done_ok, "R7", "done after last strobe", done_ok, 1);
    if (disturb)
      check(bad_bit == 0 && nstrb == TOT && bad_gap == 0, "R8",
            "stream under busy-time input changes", bad_bit + bad_gap, 0);
    @(negedge clk);
    check(!done_o && !busy_o, "R7", "idle after done", {busy_o, done_o}, 0);
  endtask

  // R1: reset in the middle of a transfer.
  task automatic t_mid_reset();
    @(negedge clk);
    cfg_i = 56'hFF_FFFF_FFFF_FFFF; gap_i = 4'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_vec() == 5'b0, "R1", "outputs after mid-transfer reset", out_vec(), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_xfer(56'h0123_4567_89AB_CD, 1, 1'b0);
    t_xfer(56'hA5_5A_F0_0F_C3_3C_81, 0, 1'b0);
    t_xfer(56'hFF_FFFF_FFFF_FFFF, 3, 1'b0);
    t_xfer(56'h80_0000_0000_0001, 2, 1'b0);
    t_xfer(56'h3C_9E_11_72_D4_06_EB, 1, 1'b1);
    t_mid_reset();
    t_xfer(56'h55_5555_5555_5555, 5, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule